// File: doc/BRIEF.md
# I2C Configuration Register Bank

This block is a serial-bus slave that holds an eight-byte configuration store. A bus master addresses it with a seven-bit device address and a direction bit. For a write it then sends a register index byte and one data byte. For a read it first sets the register index with a write phase, issues a repeated START, and then clocks out as many bytes as it wants. Every register is presented continuously on a flat 64-bit output, byte k on bits 8k+7 down to 8k, so that divider and mode logic elsewhere on the chip can use the settings directly.

Both bus lines are oversampled by a fast system clock through two-flop synchronizers. The block never needs the synthesized clock it configures. There is one exception to plain read-back. The top bit of the highest register reports a live lock flag whenever the two-bit status-mode field in that register (bits 7 and 6 of register 7) is zero.

Top module: `i2cCfgBank`

## Requirements
- R1: When the received device address equals the DEV_ADDR parameter, the slave pulls SDA low during the acknowledge clock of the device address byte, of the register index byte and of the first data byte of a write.
- R2: A write stores its data byte into the register selected by the index byte, whose low three bits are the register number. Register k then appears on cfgBits[8k+7:8k] and no other register changes.
- R3: After a write phase that sets the index, a repeated START and a read header return the selected register's contents, most significant bit first.
- R4: After reset all 64 configuration bits are zero and SDA is released.
- R5: During a read the register pointer advances by one after each byte is loaded for output, and it wraps from register 7 to register 0.
- R6: When the device address does not match, the slave does not acknowledge and ignores all further bytes until the next START. No register changes.
- R7: When bits 7:6 of register 7 are 00, reading register 7 returns the lockFlag input in bit 7. Otherwise bit 7 reads as written. cfgBits[63] always carries the written value.
- R8: A second data byte in the same write transaction is not acknowledged and is not stored in any register.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released for further clocks until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOe | output | 1 | High to pull SDA low (open-drain drive) |
| lockFlag | input | 1 | Live lock status, low means unlocked |
| cfgBits | output | 64 | All eight registers, register k at bits 8k+7:8k |

## Verification
Loading register 7 for output does two things on the same system clock edge. It captures the live lock flag into the transmit shifter, and it wraps the pointer back to register 0. A sequential read that starts at register 6 reaches this case, with the status-mode field either zero or non-zero and the lock flag held at a known level. The bench judges it from the three returned bytes: register 6, then register 7 with or without the flag substitution, then register 0, each compared against values written earlier through the bus.

// File: rtl/i2cBankPkg.sv
package i2cBankPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEVACK,
    ST_REGADDR,
    ST_REGACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } busState_t;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic shiftIn;    // sample SDA into the receive shifter
    logic shiftOut;   // advance the transmit shifter by one bit
    logic loadRead;   // load the addressed register and bump the pointer
    logic writeData;  // store the received byte at the pointer
    logic loadPtr;    // take the received byte as the pointer
  } bankStrobe_t;

endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[g] <= '1;
        else       stg[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[g] <= '1;
        else       stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/i2cBankCtrl.sv
module i2cBankCtrl
  import i2cBankPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclS,
  input  logic        sdaS,
  input  logic [7:0]  rxByte,
  input  logic        txBit,
  output bankStrobe_t strb,
  output logic        sdaOe
);

  localparam logic [3:0] LAST_BIT = 4'd8;

  busState_t  state;
  logic       sclPrev, sdaPrev;
  logic [3:0] bitCnt;
  logic       rwBit, mAck, ackDrive;

  wire sclRise  = sclS & ~sclPrev;
  wire sclFall  = ~sclS & sclPrev;
  wire startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  wire stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  wire byteDone = sclFall && (bitCnt == LAST_BIT);
  wire rxState  = (state == ST_DEVADDR) || (state == ST_REGADDR) || (state == ST_WDATA);

  always_comb begin
    strb           = '0;
    strb.shiftIn   = sclRise && rxState;
    strb.loadPtr   = byteDone && (state == ST_REGADDR);
    strb.writeData = byteDone && (state == ST_WDATA);
    strb.loadRead  = sclFall && (((state == ST_DEVACK) && rwBit) || ((state == ST_RACK) && mAck));
    strb.shiftOut  = sclFall && (state == ST_RDATA) && (bitCnt != LAST_BIT);
  end

  assign sdaOe = ackDrive | ((state == ST_RDATA) & ~txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      rwBit    <= 1'b0;
      mAck     <= 1'b0;
      ackDrive <= 1'b0;
    end else if (startDet) begin
      state    <= ST_DEVADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      case (state)
        ST_DEVADDR, ST_REGADDR, ST_WDATA, ST_RDATA: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            bitCnt <= '0;
            case (state)
              ST_DEVADDR: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  rwBit    <= rxByte[0];
                  ackDrive <= 1'b1;
                  state    <= ST_DEVACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_REGADDR: begin ackDrive <= 1'b1; state <= ST_REGACK; end
              ST_WDATA:   begin ackDrive <= 1'b1; state <= ST_WACK;   end
              default:    state <= ST_RACK;
            endcase
          end
        end
        ST_DEVACK: if (sclFall) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          state    <= rwBit ? ST_RDATA : ST_REGADDR;
        end
        ST_REGACK: if (sclFall) begin
          ackDrive <= 1'b0;
          state    <= ST_WDATA;
        end
        ST_WACK: if (sclFall) begin
          ackDrive <= 1'b0;
          state    <= ST_IDLE;   // one data byte per write
        end
        ST_RACK: begin
          if (sclRise) mAck <= ~sdaS;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= mAck ? ST_RDATA : ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  // acknowledge drive only in acknowledge slots of an addressed transfer
  assert_ack_slot_R1: assert property (@(posedge clk) disable iff (!rstN)
    ackDrive |-> (state == ST_DEVACK || state == ST_REGACK || state == ST_WACK));

  // an unmatched header never leads to an acknowledge
  assert_addr_nack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && state == ST_DEVADDR && rxByte[7:1] != DEV_ADDR && !startDet && !stopDet)
      |=> (!ackDrive && state == ST_IDLE));

  // idle slave leaves the line alone
  assert_release_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  // a write header never produces register strobes on the second data byte
  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WACK && sclFall && !startDet && !stopDet) |=> (state == ST_IDLE));

endmodule

// File: rtl/i2cBankData.sv
module i2cBankData
  import i2cBankPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStrobe_t           strb,
  input  logic                  sdaBit,
  input  logic                  lockFlag,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] cfgBits
);

  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(NUM_REGS - 1);

  logic [7:0]       regs [NUM_REGS];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rxShift, txShift, readByte;

  always_comb begin
    readByte = regs[ptr];
    if (ptr == TOP_IDX && regs[TOP_IDX][7:6] == 2'b00) readByte[7] = lockFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      ptr     <= '0;
      rxShift <= '0;
      txShift <= 8'hFF;
    end else begin
      if (strb.shiftIn)   rxShift <= {rxShift[6:0], sdaBit};
      if (strb.loadPtr)   ptr <= rxShift[PTR_W-1:0];
      if (strb.writeData) regs[ptr] <= rxShift;
      if (strb.loadRead) begin
        txShift <= readByte;
        ptr     <= ptr + 1'b1;
      end else if (strb.shiftOut) begin
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gFlat
    assign cfgBits[g*8 +: 8] = regs[g];
  end

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadPtr, strb.writeData, strb.loadRead, strb.shiftOut}));

  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeData |=> (regs[$past(ptr)] == $past(rxShift)));

  assert_ptr_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRead |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  assert_stat_override_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRead && ptr == TOP_IDX && regs[TOP_IDX][7:6] == 2'b00)
      |=> (txShift[7] == $past(lockFlag)));

endmodule

// File: rtl/i2cCfgBank.sv
module i2cCfgBank
  import i2cBankPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h5A,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic                  lockFlag,
  output logic [NUM_REGS*8-1:0] cfgBits
);

  logic        sclS, sdaS, txBit;
  logic [7:0]  rxByte;
  bankStrobe_t strb;

  i2cLineSync #(.STAGES(SYNC_STAGES), .WIDTH(2)) lineSync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sclIn, sdaIn}),
    .dout ({sclS, sdaS})
  );

  i2cBankCtrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclS   (sclS),
    .sdaS   (sdaS),
    .rxByte (rxByte),
    .txBit  (txBit),
    .strb   (strb),
    .sdaOe  (sdaOe)
  );

  i2cBankData #(.NUM_REGS(NUM_REGS)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sdaBit   (sdaS),
    .lockFlag (lockFlag),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .cfgBits  (cfgBits)
  );

endmodule

// File: tb/i2cCfgBank_tb_top.sv
`timescale 1ns/1ps
module i2cCfgBank_tb_top;

  localparam logic [6:0] DEV = 7'h5A;
  localparam int Q = 100;   // quarter bit period in ns

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1, lockFlag = 1'b0;
  logic sdaOe;
  logic [63:0] cfgBits;
  wire sdaBus = sdaM & ~sdaOe;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  i2cCfgBank #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .lockFlag(lockFlag), .cfgBits(cfgBits)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startCond();
    sdaM = 1'b1; #Q; sclM = 1'b1; #Q; sdaM = 1'b0; #Q; sclM = 1'b0; #Q;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; #Q; sclM = 1'b1; #Q; sdaM = 1'b1; #Q;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; #Q; sclM = 1'b1; #(2*Q); sclM = 1'b0; #Q;
    end
    sdaM = 1'b1; #Q; sclM = 1'b1; #Q; ack = ~sdaBus; #Q; sclM = 1'b0; #Q;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; sclM = 1'b1; #Q; b[i] = sdaBus; #Q; sclM = 1'b0; #Q;
    end
    sdaM = nack; #Q; sclM = 1'b1; #(2*Q); sclM = 1'b0; #Q; sdaM = 1'b1;
  endtask

  task automatic writeReg(input logic [7:0] idx, input logic [7:0] val);
    logic a;
    startCond(); sendByte({DEV, 1'b0}, a); sendByte(idx, a); sendByte(val, a); stopCond();
  endtask

  task automatic setPtrRead(input logic [7:0] idx);
    logic a;
    startCond(); sendByte({DEV, 1'b0}, a); sendByte(idx, a);
    startCond(); sendByte({DEV, 1'b1}, a);
  endtask

  task automatic testReset();
    chk("R4 cfg after reset", cfgBits, 64'h0);
    chk("R4 sda released", {63'h0, sdaOe}, 64'h0);
  endtask

  task automatic testWrite();
    logic a;
    startCond();
    sendByte({DEV, 1'b0}, a); chk("R1 ack device addr", {63'h0, a}, 64'h1);
    sendByte(8'h02, a);       chk("R1 ack reg index", {63'h0, a}, 64'h1);
    sendByte(8'hA5, a);       chk("R1 ack data", {63'h0, a}, 64'h1);
    stopCond();
    chk("R2 write reg2", cfgBits, 64'h0000_0000_00A5_0000);
  endtask

  task automatic testRandomRead();
    logic [7:0] d;
    setPtrRead(8'h02); recvByte(1'b1, d);
    chk("R3 random read reg2", {56'h0, d}, 64'hA5);
    chk("R9 released after nack", {63'h0, sdaOe}, 64'h0);
    recvByte(1'b1, d);
    chk("R9 stays released", {56'h0, d}, 64'hFF);
    stopCond();
  endtask

  task automatic testMismatch();
    logic a;
    startCond();
    sendByte({DEV ^ 7'h01, 1'b0}, a); chk("R6 no ack wrong addr", {63'h0, a}, 64'h0);
    sendByte(8'h01, a); chk("R6 no ack later byte", {63'h0, a}, 64'h0);
    sendByte(8'hFF, a);
    stopCond();
    chk("R6 regs unchanged", cfgBits, 64'h0000_0000_00A5_0000);
  endtask

  task automatic testExtraByte();
    logic a;
    startCond(); sendByte({DEV, 1'b0}, a); sendByte(8'h03, a);
    sendByte(8'h11, a);
    sendByte(8'h22, a); chk("R8 second byte nack", {63'h0, a}, 64'h0);
    stopCond();
    chk("R8 only first stored", cfgBits, 64'h0000_0000_11A5_0000);
  endtask

  task automatic testWrap();
    logic [7:0] d0, d1, d2;
    writeReg(8'h06, 8'h3C); writeReg(8'h07, 8'h41); writeReg(8'h00, 8'h99);
    lockFlag = 1'b1;
    setPtrRead(8'h06);
    recvByte(1'b0, d0); recvByte(1'b0, d1); recvByte(1'b1, d2); stopCond();
    chk("R5 seq byte reg6", {56'h0, d0}, 64'h3C);
    chk("R5 seq byte reg7 no override", {56'h0, d1}, 64'h41);
    chk("R5 wrap to reg0", {56'h0, d2}, 64'h99);
  endtask

  task automatic testStatus();
    logic [7:0] d;
    writeReg(8'h07, 8'h00);
    lockFlag = 1'b1; setPtrRead(8'h07); recvByte(1'b1, d); stopCond();
    chk("R7 flag high read", {56'h0, d}, 64'h80);
    chk("R7 cfg63 written value", {63'h0, cfgBits[63]}, 64'h0);
    lockFlag = 1'b0; setPtrRead(8'h07); recvByte(1'b1, d); stopCond();
    chk("R7 flag low read", {56'h0, d}, 64'h00);
    writeReg(8'h07, 8'h80);
    setPtrRead(8'h07); recvByte(1'b1, d); stopCond();
    chk("R7 stat10 reads as written", {56'h0, d}, 64'h80);
    chk("R7 cfg63 set", {63'h0, cfgBits[63]}, 64'h1);
  endtask

  initial begin
    #51 rstN = 1'b1;
    #20;
    testReset();
    testWrite();
    testRandomRead();
    testMismatch();
    testExtraByte();
    testWrap();
    testStatus();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule